// File: doc/BRIEF.md
# Timer Channel Interrupt Gather Register

This block merges the event pulses of five timer channels into a single 32-bit control/status word and turns them into one level interrupt per channel. Each timer delivers a one-cycle event pulse. The block latches that pulse into the channel's pending flag, and the flag stays set until software clears it. A per-channel enable decides whether a pending flag reaches that channel's interrupt output. The enable has no effect on whether the flag is latched.

Software sees one word through a plain write strobe with write data and a continuous read value. The low field of the word holds the enables and the field just above it holds the pending flags. Pending flags are write-one-to-clear. Writing a zero into a pending position changes nothing. Because of this, a read-modify-write that zeroes the pending field before writing back can change the enables without losing any pending events. Each interrupt output is the AND of a channel's pending flag and enable, registered for one cycle.

Top module: `tmr_irq_csr`

## Requirements
- R1: After reset the read value is all zeros and every interrupt output is low.
- R2: Bits 4:0 of the word are enables that can be read and written, and bit n belongs to channel n. A write stores wdata[4:0], and the enables hold their value when there is no write.
- R3: A high pulse on timer event input n sets the pending flag at bit n+5 on that clock edge. This happens whether or not channel n is enabled.
- R4: A write with a 1 at bit n+5 clears channel n's pending flag when no event arrives for that channel in the same cycle.
- R5: A write with a 0 at bit n+5 leaves channel n's pending flag as it was.
- R6: When an event and a clearing write hit the same channel in the same cycle, the pending flag ends up set.
- R7: Bits 31:10 always read as zero, and writing ones to them has no visible effect.
- R8: Interrupt output n equals pending[n] AND enable[n] as they stood one cycle earlier.
- R9: A pending flag, and with it an enabled channel's interrupt output, stays asserted over any number of idle cycles until a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_evt | input | 5 | One-cycle event pulse per timer channel |
| csr_we | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Write data: enables in 4:0, clear mask in 9:5 |
| csr_rdata | output | 32 | Current word: enables in 4:0, pending in 9:5, zeros above |
| irq_out | output | 5 | Level interrupt per channel, registered |

## Verification
A timer event and a clearing write can fall on the same channel in the same clock cycle. The bench provokes this by first setting channel 2's pending flag. It then drives the event pulse, the write strobe and a 1 at bit 7 together for one cycle. The flag must still read set afterwards. In the same write, channel 1 is cleared with no event present, so the bench also confirms that the clear works when there is no collision.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int unsigned TMR_CH = 5;
   localparam int unsigned CSR_W  = 32;
endpackage

// File: rtl/tmr_irq_pend_cell.sv
module tmr_irq_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_o <= 1'b0;
      else if (evt_i) pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
   end

   // R6
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> pend_o);
   // R4
   clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !pend_o);
   // R9
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i && !clr_i) |=> $stable(pend_o));
endmodule

// File: rtl/tmr_irq_en_reg.sv
module tmr_irq_en_reg #(
   parameter int unsigned NUM_CH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [NUM_CH-1:0] data_i,
   output logic [NUM_CH-1:0] en_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_o <= '0;
      else if (we_i) en_o <= data_i;
   end

   // R2
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (en_o == $past(data_i)));
   // R2
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(en_o));
endmodule

// File: rtl/tmr_irq_out_stage.sv
module tmr_irq_out_stage #(
   parameter int unsigned NUM_CH  = 5,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pend_i,
   input  logic [NUM_CH-1:0] en_i,
   output logic [NUM_CH-1:0] irq_o
);
   logic [NUM_CH-1:0] gated;
   assign gated = pend_i & en_i;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= '0;
            else        irq_o <= gated;
         end
         // R8
         irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o == $past(pend_i & en_i)));
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o = gated;
      end
   endgenerate
endmodule

// File: rtl/tmr_irq_csr.sv
module tmr_irq_csr #(
   parameter int unsigned NUM_CH  = tmr_irq_pkg::TMR_CH,
   parameter int unsigned DATA_W  = tmr_irq_pkg::CSR_W,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tmr_evt,
   input  logic              csr_we,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   output logic [NUM_CH-1:0] irq_out
);
   localparam int unsigned EN_LSB   = 0;
   localparam int unsigned PEND_LSB = EN_LSB + NUM_CH;
   localparam int unsigned USED_W   = PEND_LSB + NUM_CH;

   generate
      if (USED_W > DATA_W) begin : g_bad_width
         $error("tmr_irq_csr: word too narrow for enable and pending fields");
      end
      if (NUM_CH == 0) begin : g_bad_count
         $error("tmr_irq_csr: NUM_CH must be nonzero");
      end
   endgenerate

   logic [NUM_CH-1:0] en_q;
   logic [NUM_CH-1:0] pend_q;
   logic [NUM_CH-1:0] clr_req;

   assign clr_req = {NUM_CH{csr_we}} & csr_wdata[PEND_LSB +: NUM_CH];

   tmr_irq_en_reg #(.NUM_CH(NUM_CH)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (csr_we),
      .data_i (csr_wdata[EN_LSB +: NUM_CH]),
      .en_o   (en_q)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      tmr_irq_pend_cell u_pend (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (tmr_evt[ch]),
         .clr_i  (clr_req[ch]),
         .pend_o (pend_q[ch])
      );
   end

   tmr_irq_out_stage #(.NUM_CH(NUM_CH), .REG_OUT(REG_OUT)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend_q),
      .en_i   (en_q),
      .irq_o  (irq_out)
   );

   always_comb begin
      csr_rdata = '0;
      csr_rdata[EN_LSB +: NUM_CH]   = en_q;
      csr_rdata[PEND_LSB +: NUM_CH] = pend_q;
   end

   generate
      if (DATA_W > USED_W) begin : g_upper
         // R7
         upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_we && (|csr_wdata[DATA_W-1:USED_W]))
               |=> (csr_rdata[DATA_W-1:USED_W] == '0));
      end
   endgenerate

   // R3
   evt_any_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|tmr_evt) |=> ((csr_rdata[PEND_LSB +: NUM_CH] & $past(tmr_evt)) == $past(tmr_evt)));
endmodule

// File: tb/test_tmr_irq_csr.sv
module test_tmr_irq_csr;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  tmr_evt = '0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic [4:0]  irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_irq_csr i_tmr_irq_csr (
      .clk(clk), .rst_n(rst_n), .tmr_evt(tmr_evt), .csr_we(csr_we),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      csr_we = 1'b1; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic evt(input logic [4:0] m);
      tmr_evt = m;
      @(negedge clk);
      tmr_evt = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 rdata", csr_rdata, 32'h0);
      chk("R1 irq", {27'h0, irq_out}, 32'h0);
   endtask

   task automatic t_enable;
      wr(32'hFFC0_0015);
      chk("R2 enables", csr_rdata, 32'h0000_0015);
      chk("R7 upper bits", {10'h0, csr_rdata[31:10]}, 32'h0);
   endtask

   task automatic t_pend_disabled;
      evt(5'b00010);
      chk("R3 pending while disabled", csr_rdata, 32'h0000_0055);
      idle(2);
      chk("R8 disabled channel quiet", {27'h0, irq_out}, 32'h0);
   endtask

   task automatic t_irq_timing;
      evt(5'b00001);
      chk("R3 pending ch0", csr_rdata, 32'h0000_0075);
      chk("R8 irq not yet", {27'h0, irq_out}, 32'h0);
      idle(1);
      chk("R8 irq one cycle later", {27'h0, irq_out}, 32'h1);
      idle(5);
      chk("R9 level held", {27'h0, irq_out}, 32'h1);
      chk("R9 pending held", csr_rdata, 32'h0000_0075);
   endtask

   task automatic t_rmw;
      wr((csr_rdata & 32'h1F) | 32'h0A);
      chk("R5 pending kept on zero write", csr_rdata, 32'h0000_007F);
      idle(1);
      chk("R8 ch1 now enabled", {27'h0, irq_out}, 32'h3);
   endtask

   task automatic t_clear;
      wr(32'h0000_003F);
      chk("R4 clear ch0", csr_rdata, 32'h0000_005F);
      chk("R8 irq lags clear", {27'h0, irq_out}, 32'h3);
      idle(1);
      chk("R8 irq drops", {27'h0, irq_out}, 32'h2);
   endtask

   task automatic t_collide;
      evt(5'b00100);
      chk("R3 pending ch2", csr_rdata, 32'h0000_00DF);
      tmr_evt = 5'b00100; csr_we = 1'b1; csr_wdata = 32'h0000_00DF;
      @(negedge clk);
      tmr_evt = '0; csr_we = 1'b0; csr_wdata = '0;
      chk("R6 event wins over clear", csr_rdata & 32'h80, 32'h80);
      chk("R4 ch1 cleared alongside", csr_rdata & 32'h40, 32'h0);
   endtask

   task automatic t_all;
      evt(5'b11111);
      chk("R3 all pending", csr_rdata[9:5], 32'h1F);
      wr(32'hFFFF_FFE0);
      chk("R4 all cleared, enables off", csr_rdata, 32'h0);
      idle(1);
      chk("R8 all quiet", {27'h0, irq_out}, 32'h0);
   endtask

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_enable();
      t_pend_disabled();
      t_irq_timing();
      t_rmw();
      t_clear();
      t_collide();
      t_all();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule